// File: doc/BRIEF.md
# Minifloat Adder

This block adds two 8-bit floating-point operands and returns an 8-bit floating-point sum. The sum comes with an overflow flag and an invalid-operation flag. In the word format the sign is bit 7, a 3-bit exponent with bias 3 is bits 6..4, and a 4-bit fraction is bits 3..0. A normal value carries a hidden leading one. An exponent field of zero marks zero or a subnormal value, which has no hidden one and uses an effective exponent of 1. An exponent field of all ones marks infinity (zero fraction) or NaN (nonzero fraction). The `subtract` input flips the sign of the second operand before the addition.

The datapath runs in two registered stages. The first stage classifies the operands, orders them by magnitude and shifts the smaller significand right. It keeps a guard bit, a round bit and a sticky bit. The second stage adds or subtracts the aligned significands, normalizes the result, rounds it to nearest with ties to even and packs the result word. A one-bit valid travels alongside the data. The block accepts a new operation on every clock cycle.

Top module: `mini_fp_adder`

## Requirements
- R1: A finite sum that is exactly representable is returned exactly. Value = 1.f × 2^(e−3) for exponent field e in 1..6, and 0.f × 2^−2 for e = 0. Example: 0x30 (1.0) minus 0x20 (0.5) gives 0x20.
- R2: An inexact finite sum rounds to the nearest representable value. A tie goes to the code with an even fraction. 0x4F + 0x16 gives 0x51. 0x30 + 0x02 gives 0x30. 0x31 + 0x02 gives 0x32.
- R3: When finite operands give a sum whose rounded magnitude exceeds 15.5, the result is infinity of the sum's sign (0x70 or 0xF0) and `overflow` is 1.
- R4: If either operand is NaN, the result is the NaN code 0x78, and `overflow` and `invalid` stay 0.
- R5: Adding infinities of opposite effective sign gives 0x78 with `invalid` = 1.
- R6: Infinity combined with a finite operand, or with an infinity of the same sign, gives that infinity, with both flags 0.
- R7: Every zero result is +0 (0x00), including exact cancellation of opposite-signed operands. 0x80 is never produced.
- R8: With `subtract` = 1, the result is that of adding `opA` to `opB` with bit 7 of `opB` inverted.
- R9: `outValid` rises exactly two clock edges after an edge that samples `inValid` high, and lasts one cycle per operation. A new operation can be issued on every cycle. Result outputs hold their value while `outValid` is low.
- R10: While `rstN` is low, `outValid`, `sum`, `overflow` and `invalid` are all 0, and an operation in flight is discarded.
- R11: Sums below 0.25 in magnitude come out as subnormal codes (exponent field 0). A subnormal sum that reaches 0.25 becomes the normal code 0x10 or 0x90.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on this cycle are to be processed |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| subtract | input | 1 | Invert sign of opB before adding |
| outValid | output | 1 | Result outputs carry a new result |
| sum | output | 8 | Rounded result word |
| overflow | output | 1 | Finite operands produced an out-of-range sum |
| invalid | output | 1 | Opposite-signed infinities were added |

## Verification
The result, `outValid` and both flags for an operation are due after the second rising edge following the edge that sampled `inValid`. No output changes earlier. The bench drives inputs on falling edges. Single-shot checks look at the falling edge one cycle after the drive, where `outValid` must still be low, then at the next falling edge for the result, then one more for the hold. For the exhaustive sweep, a new operation is issued on every cycle and the expected results are pushed onto a queue. The queue is popped on each falling edge where `outValid` is high, so the data must come out in order and with no gaps.

// File: rtl/mfadd_pkg.sv
package mfadd_pkg;
  localparam int EXP_W  = 3;
  localparam int FRAC_W = 4;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int GRS_W  = 3;
  localparam int ALN_W  = SIG_W + GRS_W;

  typedef struct packed {
    logic loadAlign;
    logic loadResult;
  } ctrlStrobes_t;
endpackage

// File: rtl/mfadd_ctrl.sv
module mfadd_ctrl
  import mfadd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  logic alignValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      alignValid <= inValid;
      outValid   <= alignValid;
    end
  end

  assign strobes.loadAlign  = inValid;
  assign strobes.loadResult = alignValid;

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);
  // R9
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid, 2));
endmodule

// File: rtl/mfadd_datapath.sv
module mfadd_datapath
  import mfadd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subtract,
  output logic [WORD_W-1:0] sum,
  output logic              overflow,
  output logic              invalid
);
  localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [EXP_W-1:0]  EXP_MIN   = EXP_W'(1);
  localparam logic [EXP_W:0]    EXP_STEP  = (EXP_W+1)'(1);
  localparam logic [EXP_W:0]    EXP_LIMIT = {1'b0, EXP_ONES};
  localparam logic [WORD_W-1:0] NAN_CODE  = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  // ---------------- stage 1: classify, order, align ----------------
  logic              signA, signB;
  logic [EXP_W-1:0]  expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic              nanA, nanB, infA, infB, swap;

  assign signA = opA[WORD_W-1];
  assign signB = opB[WORD_W-1] ^ subtract;
  assign expA  = opA[WORD_W-2 -: EXP_W];
  assign expB  = opB[WORD_W-2 -: EXP_W];
  assign fracA = opA[FRAC_W-1:0];
  assign fracB = opB[FRAC_W-1:0];
  assign nanA  = (expA == EXP_ONES) && (fracA != '0);
  assign nanB  = (expB == EXP_ONES) && (fracB != '0);
  assign infA  = (expA == EXP_ONES) && (fracA == '0);
  assign infB  = (expB == EXP_ONES) && (fracB == '0);
  assign swap  = opB[WORD_W-2:0] > opA[WORD_W-2:0];

  logic              bigSign, smallSign;
  logic [EXP_W-1:0]  bigExp, smallExp, effBig, effSmall, expDiff;
  logic [FRAC_W-1:0] bigFrac, smallFrac;
  logic [SIG_W-1:0]  sigBig, sigSmall;
  logic [2*ALN_W-1:0] shiftWide;
  logic [ALN_W-1:0]  alignedSmall;
  int                shiftAmt;

  always_comb begin
    if (swap) begin
      bigSign = signB; bigExp = expB; bigFrac = fracB;
      smallSign = signA; smallExp = expA; smallFrac = fracA;
    end else begin
      bigSign = signA; bigExp = expA; bigFrac = fracA;
      smallSign = signB; smallExp = expB; smallFrac = fracB;
    end
  end

  assign effBig   = (bigExp == '0) ? EXP_MIN : bigExp;
  assign effSmall = (smallExp == '0) ? EXP_MIN : smallExp;
  assign sigBig   = {bigExp != '0, bigFrac};
  assign sigSmall = {smallExp != '0, smallFrac};
  assign expDiff  = effBig - effSmall;

  always_comb begin
    shiftAmt  = (int'(expDiff) > ALN_W) ? ALN_W : int'(expDiff);
    shiftWide = {sigSmall, {GRS_W{1'b0}}, {ALN_W{1'b0}}} >> shiftAmt;
    alignedSmall = shiftWide[2*ALN_W-1:ALN_W]
                 | {{(ALN_W-1){1'b0}}, |shiftWide[ALN_W-1:0]};
  end

  logic              specValid, specInv;
  logic [WORD_W-1:0] specCode;

  always_comb begin
    specValid = 1'b0;
    specInv   = 1'b0;
    specCode  = NAN_CODE;
    if (nanA || nanB) begin
      specValid = 1'b1;
    end else if (infA && infB) begin
      specValid = 1'b1;
      if (signA != signB) specInv = 1'b1;
      else specCode = {signA, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (infA) begin
      specValid = 1'b1;
      specCode  = {signA, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (infB) begin
      specValid = 1'b1;
      specCode  = {signB, EXP_ONES, {FRAC_W{1'b0}}};
    end
  end

  logic              s1Sign, s1Sub, s1Special, s1SpecInv;
  logic [EXP_W:0]    s1Exp;
  logic [ALN_W-1:0]  s1BigSig, s1SmallSig;
  logic [WORD_W-1:0] s1SpecCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sign     <= 1'b0;
      s1Sub      <= 1'b0;
      s1Special  <= 1'b0;
      s1SpecInv  <= 1'b0;
      s1Exp      <= '0;
      s1BigSig   <= '0;
      s1SmallSig <= '0;
      s1SpecCode <= '0;
    end else if (strobes.loadAlign) begin
      s1Sign     <= bigSign;
      s1Sub      <= bigSign != smallSign;
      s1Special  <= specValid;
      s1SpecInv  <= specInv;
      s1Exp      <= {1'b0, effBig};
      s1BigSig   <= {sigBig, {GRS_W{1'b0}}};
      s1SmallSig <= alignedSmall;
      s1SpecCode <= specCode;
    end
  end

  // ---------------- stage 2: add, normalize, round, pack ----------------
  logic [ALN_W:0]   rawSum;
  logic [ALN_W-1:0] normSig;
  logic [EXP_W:0]   normExp, finalExp;
  logic             roundUp, hiddenBit, isZero, ovfNow;
  logic [SIG_W:0]   rounded;

  assign rawSum = s1Sub ? ({1'b0, s1BigSig} - {1'b0, s1SmallSig})
                        : ({1'b0, s1BigSig} + {1'b0, s1SmallSig});

  always_comb begin
    normExp = s1Exp;
    if (rawSum[ALN_W]) begin
      normSig = rawSum[ALN_W:1] | {{(ALN_W-1){1'b0}}, rawSum[0]};
      normExp = s1Exp + EXP_STEP;
    end else begin
      normSig = rawSum[ALN_W-1:0];
      for (int i = 0; i < ALN_W; i++) begin
        if (!normSig[ALN_W-1] && (normExp > EXP_STEP)) begin
          normSig = normSig << 1;
          normExp = normExp - EXP_STEP;
        end
      end
    end
  end

  assign roundUp   = normSig[GRS_W-1] & (normSig[GRS_W] | (|normSig[GRS_W-2:0]));
  assign rounded   = {1'b0, normSig[ALN_W-1:GRS_W]} + {{SIG_W{1'b0}}, roundUp};
  assign finalExp  = rounded[SIG_W] ? normExp + EXP_STEP : normExp;
  assign hiddenBit = rounded[SIG_W] | rounded[SIG_W-1];
  assign isZero    = rawSum == '0;
  assign ovfNow    = !isZero && (finalExp >= EXP_LIMIT);

  logic [WORD_W-1:0] resWord;
  logic              resOvf, resInv;

  always_comb begin
    resOvf = 1'b0;
    resInv = 1'b0;
    if (s1Special) begin
      resWord = s1SpecCode;
      resInv  = s1SpecInv;
    end else if (isZero) begin
      resWord = '0;
    end else if (ovfNow) begin
      resWord = {s1Sign, EXP_ONES, {FRAC_W{1'b0}}};
      resOvf  = 1'b1;
    end else begin
      resWord = {s1Sign, hiddenBit ? finalExp[EXP_W-1:0] : {EXP_W{1'b0}},
                 rounded[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sum      <= '0;
      overflow <= 1'b0;
      invalid  <= 1'b0;
    end else if (strobes.loadResult) begin
      sum      <= resWord;
      overflow <= resOvf;
      invalid  <= resInv;
    end
  end

  // R3
  overflow_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (sum[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}} && !invalid));
  // R5
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalid |-> (sum == NAN_CODE));
  // R7
  no_negzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    sum != {1'b1, {(WORD_W-1){1'b0}}});
  // R4
  nan_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadAlign && (nanA || nanB)) |=> ##1 (sum == NAN_CODE && !invalid && !overflow));
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> $stable(sum));
endmodule

// File: rtl/mini_fp_adder.sv
module mini_fp_adder
  import mfadd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subtract,
  output logic              outValid,
  output logic [WORD_W-1:0] sum,
  output logic              overflow,
  output logic              invalid
);
  ctrlStrobes_t strobes;

  mfadd_ctrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  mfadd_datapath datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .subtract (subtract),
    .sum      (sum),
    .overflow (overflow),
    .invalid  (invalid)
  );
endmodule

// File: tb/mini_fp_adder_test.sv
module mini_fp_adder_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic       subtract = 1'b0;
  logic       outValid;
  logic [7:0] sum;
  logic       overflow;
  logic       invalid;

  int errors = 0;
  int checks = 0;
  bit streamOn = 1'b0;
  int streamCount = 0;
  logic [9:0] expQ[$];

  always #2 clk = ~clk;

  mini_fp_adder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subtract(subtract), .outValid(outValid), .sum(sum),
    .overflow(overflow), .invalid(invalid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // magnitude of a finite code in units of 2^-6
  function automatic int unitVal(input logic [6:0] m);
    int e = int'(m[6:4]);
    int f = int'(m[3:0]);
    if (e == 0) return f;
    return (16 + f) << (e - 1);
  endfunction

  // returns {invalid, overflow, sum}
  function automatic logic [9:0] refAdd(input logic [7:0] a, input logic [7:0] b0, input bit sub);
    logic [7:0] b = {b0[7] ^ sub, b0[6:0]};
    bit nA = (a[6:4] == 3'b111) && (a[3:0] != 0);
    bit nB = (b[6:4] == 3'b111) && (b[3:0] != 0);
    bit iA = (a[6:4] == 3'b111) && (a[3:0] == 0);
    bit iB = (b[6:4] == 3'b111) && (b[3:0] == 0);
    int s, mag, best, bestD, d;
    bit neg;
    if (nA || nB) return {2'b00, 8'h78};
    if (iA && iB) return (a[7] != b[7]) ? {2'b10, 8'h78} : {2'b00, a};
    if (iA) return {2'b00, a};
    if (iB) return {2'b00, b};
    s = (a[7] ? -unitVal(a[6:0]) : unitVal(a[6:0])) + (b[7] ? -unitVal(b[6:0]) : unitVal(b[6:0]));
    if (s == 0) return 10'h000;
    neg = s < 0;
    mag = neg ? -s : s;
    if (mag >= 1008) return {2'b01, neg, 7'h70};
    best = 0;
    bestD = 1 << 20;
    for (int c = 0; c < 112; c++) begin
      d = unitVal(7'(c)) - mag;
      if (d < 0) d = -d;
      if (d < bestD || (d == bestD && (c % 2) == 0)) begin
        bestD = d;
        best = c;
      end
    end
    return {2'b00, neg, 7'(best)};
  endfunction

  task automatic runOne(input logic [7:0] a, input logic [7:0] b, input bit sub,
                        input logic [7:0] expSum, input bit expOvf, input bit expInv,
                        input string req);
    logic [7:0] held;
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; subtract = sub;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R9", "early outValid", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R9", "outValid at 2 cycles", int'(outValid), 1);
    check(sum == expSum, req, "sum", int'(sum), int'(expSum));
    check(overflow == expOvf, req, "overflow", int'(overflow), int'(expOvf));
    check(invalid == expInv, req, "invalid", int'(invalid), int'(expInv));
    held = sum;
    @(negedge clk);
    check(outValid == 1'b0 && sum == held, "R9", "single pulse and hold",
          int'({outValid, sum}), int'({1'b0, held}));
  endtask

  // streaming checker
  always @(negedge clk) begin
    if (streamOn && outValid) begin
      logic [9:0] e;
      string tag;
      streamCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected result", int'(sum), 0);
      end else begin
        e = expQ.pop_front();
        tag = e[9] ? "R5" : (e[8] ? "R3" : "R1");
        check({invalid, overflow, sum} == e, tag, "sweep result",
              int'({invalid, overflow, sum}), int'(e));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check({outValid, sum, overflow, invalid} == 11'h0, "R10", "reset outputs",
          int'({outValid, sum, overflow, invalid}), 0);
    rstN = 1'b1;

    // R10: reset discards an operation in flight
    @(negedge clk);
    inValid = 1'b1; opA = 8'h35; opB = 8'h35;
    @(negedge clk);
    inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && sum == 8'h00, "R10", "flush in flight",
          int'({outValid, sum}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R10", "no late result", int'(outValid), 0);

    // directed table
    runOne(8'h4F, 8'h16, 1'b0, 8'h51, 1'b0, 1'b0, "R2");
    runOne(8'h30, 8'h02, 1'b0, 8'h30, 1'b0, 1'b0, "R2");
    runOne(8'h31, 8'h02, 1'b0, 8'h32, 1'b0, 1'b0, "R2");
    runOne(8'h30, 8'h20, 1'b1, 8'h20, 1'b0, 1'b0, "R1");
    runOne(8'h6F, 8'h6F, 1'b0, 8'h70, 1'b1, 1'b0, "R3");
    runOne(8'hEF, 8'hEF, 1'b0, 8'hF0, 1'b1, 1'b0, "R3");
    runOne(8'h6F, 8'h10, 1'b0, 8'h70, 1'b1, 1'b0, "R3");
    runOne(8'h79, 8'h30, 1'b0, 8'h78, 1'b0, 1'b0, "R4");
    runOne(8'h70, 8'hF0, 1'b0, 8'h78, 1'b0, 1'b1, "R5");
    runOne(8'h70, 8'h70, 1'b1, 8'h78, 1'b0, 1'b1, "R8");
    runOne(8'h70, 8'h35, 1'b0, 8'h70, 1'b0, 1'b0, "R6");
    runOne(8'hF0, 8'h6F, 1'b0, 8'hF0, 1'b0, 1'b0, "R6");
    runOne(8'h35, 8'h35, 1'b1, 8'h00, 1'b0, 1'b0, "R7");
    runOne(8'hB5, 8'h35, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    runOne(8'h80, 8'h80, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    runOne(8'h01, 8'h01, 1'b0, 8'h02, 1'b0, 1'b0, "R11");
    runOne(8'h08, 8'h08, 1'b0, 8'h10, 1'b0, 1'b0, "R11");
    runOne(8'h10, 8'h01, 1'b1, 8'h0F, 1'b0, 1'b0, "R11");

    // exhaustive sweep, one operation per cycle
    streamOn = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          @(negedge clk);
          inValid = 1'b1; opA = 8'(a); opB = 8'(b); subtract = s[0];
          expQ.push_back(refAdd(8'(a), 8'(b), s[0]));
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    streamOn = 1'b0;
    // R9: throughput, one result per issued operation
    check(streamCount == 131072 && expQ.size() == 0, "R9", "sweep result count",
          streamCount, 131072);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule